// File: doc/BRIEF.md
# Bitplane fetch slot sequencer

This block decides, slot by slot, whether the display fetch engine claims the memory slot and which bitplane it reads. Each clock is one memory slot; the slot counter of the line arrives on `slot_i`. The programmed window has a start slot and a stop slot. Inside that window the block walks a repeating group of slot positions. Each position stands for a fixed plane number, and the planes are interleaved rather than taken in order.

Low resolution uses an 8-slot group and high resolution a 4-slot group. The group phase is counted from the effective start slot. That start slot is never earlier than a fixed floor. Fetching runs to the end of the group that holds the stop slot. A position whose plane is not enabled gives its slot back to the other requesters.

A plane count of seven is a special case. It fetches like four planes but reports six planes to the display side, so the data of planes 5 and 6 is not refreshed. A pulse marks each fetch of plane 1, which ends a group. Downstream logic uses it to load its shift registers in parallel.

Top module: `bpl_fetch_seq`

## Requirements
- R1: In low resolution (`hires_i`=0) the group position is k = (slot − effective start) mod 8. Positions 1,2,3,5,6,7 carry planes 4,6,2,3,5,1 respectively, and positions 0 and 4 never request.
- R2: In high resolution (`hires_i`=1) the group position is k = (slot − effective start) mod 4. Positions 0,1,2,3 carry planes 4,2,3,1, so no plane above 4 is ever requested.
- R3: A position whose plane number exceeds the fetch count makes no request. The fetch count is `plane_req_i`, or 4 when that value is 7. Whenever `fetch_req_o` is 0, `fetch_plane_o` reads 0.
- R4: With `plane_req_i`=0 no request is made in any slot, and `disp_planes_o` is 0.
- R5: `disp_planes_o` equals `plane_req_i` for values 0 to 6 and equals 6 for 7. With 7, planes 5 and 6 are never requested.
- R6: The effective start is the larger of `win_start_i` and MIN_START (default 24). No request is made for a slot below the effective start.
- R7: Requests stop after the last slot of the group that contains `win_stop_i`. If `win_stop_i` is below the effective start, no request is made at all.
- R8: `group_load_o` is 1 exactly when the block requests plane 1.
- R9: All outputs are registered. They describe the inputs sampled at the previous rising clock edge, and an active-low reset clears all of them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one memory slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hires_i | input | 1 | 1 selects the 4-slot high-resolution group |
| plane_req_i | input | 3 | Requested plane count, 0 to 7 |
| win_start_i | input | SLOT_W | Programmed first fetch slot |
| win_stop_i | input | SLOT_W | Programmed stop slot |
| slot_i | input | SLOT_W | Current slot number within the line |
| fetch_req_o | output | 1 | The fetch engine claims this slot |
| fetch_plane_o | output | 3 | Plane to read, 1 to 6, 0 when idle |
| disp_planes_o | output | 3 | Plane count used by the display side |
| group_load_o | output | 1 | Plane 1 fetched; group complete |

## Verification
The bench builds the block with its default parameters: SLOT_W of 9 and a start floor of 24. With those values every slot of a 228-slot line can be swept, and the window can start below, at or above the floor. Stop slots can fall on, before or inside a group boundary, and the last group can run past the stop slot. Both group lengths are reachable, and so are all eight plane-count codes, including zero and the seven-plane case.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

   localparam int PLANE_W     = 3;
   localparam int LO_GROUP_SH = 3;
   localparam int HI_GROUP_SH = 2;
   localparam int MAX_PLANES  = 6;
   localparam int ODD_REQ     = 7;
   localparam int ODD_FETCH   = 4;
   localparam int ODD_SHOW    = 6;

   typedef logic [PLANE_W-1:0] plane_t;

   // low-resolution group: two idle positions, planes interleaved
   function automatic plane_t lo_plane(input int pos);
      case (pos)
         1:       return plane_t'(4);
         2:       return plane_t'(6);
         3:       return plane_t'(2);
         5:       return plane_t'(3);
         6:       return plane_t'(5);
         7:       return plane_t'(1);
         default: return plane_t'(0);
      endcase
   endfunction

   // high-resolution group: four planes, plane 1 last
   function automatic plane_t hi_plane(input int pos);
      case (pos)
         0:       return plane_t'(4);
         1:       return plane_t'(2);
         2:       return plane_t'(3);
         default: return plane_t'(1);
      endcase
   endfunction

endpackage

// File: rtl/bpl_window.sv
module bpl_window #(
   parameter int SLOT_W    = 9,
   parameter int MIN_START = 24,
   parameter int GROUP_SH  = 3
) (
   input  logic [SLOT_W-1:0]   slot,
   input  logic [SLOT_W-1:0]   win_start,
   input  logic [SLOT_W-1:0]   win_stop,
   output logic                in_win,
   output logic [GROUP_SH-1:0] phase
);
   localparam logic [SLOT_W-1:0] FLOOR = SLOT_W'(MIN_START);

   initial begin
      assert (MIN_START >= 0 && MIN_START < (1 << SLOT_W))
         else $error("MIN_START does not fit in SLOT_W");
      assert (GROUP_SH > 0 && GROUP_SH < SLOT_W)
         else $error("GROUP_SH out of range");
   end

   logic [SLOT_W-1:0] eff_start;
   logic [SLOT_W-1:0] rel_slot;
   logic [SLOT_W-1:0] rel_stop;
   logic              past_start;
   logic              stop_ok;
   logic              same_or_before;

   always_comb begin
      eff_start      = (win_start < FLOOR) ? FLOOR : win_start;
      rel_slot       = slot - eff_start;
      rel_stop       = win_stop - eff_start;
      past_start     = (slot >= eff_start);
      stop_ok        = (win_stop >= eff_start);
      same_or_before = ((rel_slot >> GROUP_SH) <= (rel_stop >> GROUP_SH));
      in_win         = past_start && stop_ok && same_or_before;
      phase          = rel_slot[GROUP_SH-1:0];
   end
endmodule

// File: rtl/bpl_order_rom.sv
module bpl_order_rom
   import bpl_pkg::*;
#(
   parameter int GROUP_SH = 3,
   parameter bit HIRES    = 1'b0
) (
   input  logic [GROUP_SH-1:0] phase,
   output plane_t              plane
);
   localparam int GROUP = 1 << GROUP_SH;

   initial begin
      assert (HIRES ? (GROUP_SH == HI_GROUP_SH) : (GROUP_SH == LO_GROUP_SH))
         else $error("group length does not match order variant");
   end

   plane_t tbl [GROUP];

   for (genvar i = 0; i < GROUP; i++) begin : g_ent
      if (HIRES) begin : g_hi
         assign tbl[i] = hi_plane(i);
      end else begin : g_lo
         assign tbl[i] = lo_plane(i);
      end
   end

   assign plane = tbl[phase];
endmodule

// File: rtl/bpl_count_map.sv
module bpl_count_map
   import bpl_pkg::*;
(
   input  plane_t req,
   output plane_t fetch_cnt,
   output plane_t disp_cnt
);
   initial begin
      assert (ODD_FETCH <= MAX_PLANES && ODD_SHOW <= MAX_PLANES)
         else $error("odd-count mapping exceeds plane set");
   end

   logic odd;

   always_comb begin
      odd       = (req == plane_t'(ODD_REQ));
      fetch_cnt = odd ? plane_t'(ODD_FETCH) : req;
      disp_cnt  = odd ? plane_t'(ODD_SHOW)  : req;
   end
endmodule

// File: rtl/bpl_fetch_seq.sv
module bpl_fetch_seq
   import bpl_pkg::*;
#(
   parameter int SLOT_W    = 9,
   parameter int MIN_START = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hires_i,
   input  logic [2:0]        plane_req_i,
   input  logic [SLOT_W-1:0] win_start_i,
   input  logic [SLOT_W-1:0] win_stop_i,
   input  logic [SLOT_W-1:0] slot_i,
   output logic              fetch_req_o,
   output logic [2:0]        fetch_plane_o,
   output logic [2:0]        disp_planes_o,
   output logic              group_load_o
);
   initial begin
      assert (SLOT_W > LO_GROUP_SH) else $error("SLOT_W too small");
   end

   plane_t lane_plane [2];

   // variant 0: low resolution, variant 1: high resolution
   for (genvar v = 0; v < 2; v++) begin : g_lane
      localparam int SH = (v == 1) ? HI_GROUP_SH : LO_GROUP_SH;
      logic          in_win;
      logic [SH-1:0] phase;
      plane_t        rom_plane;

      bpl_window #(.SLOT_W(SLOT_W), .MIN_START(MIN_START), .GROUP_SH(SH)) win_i (
         .slot      (slot_i),
         .win_start (win_start_i),
         .win_stop  (win_stop_i),
         .in_win    (in_win),
         .phase     (phase)
      );

      bpl_order_rom #(.GROUP_SH(SH), .HIRES(v == 1)) rom_i (
         .phase (phase),
         .plane (rom_plane)
      );

      assign lane_plane[v] = in_win ? rom_plane : plane_t'(0);
   end

   plane_t fetch_cnt;
   plane_t disp_cnt;

   bpl_count_map map_i (
      .req       (plane_req_i),
      .fetch_cnt (fetch_cnt),
      .disp_cnt  (disp_cnt)
   );

   plane_t sel_plane;
   logic   req_c;

   always_comb begin
      sel_plane = hires_i ? lane_plane[1] : lane_plane[0];
      req_c     = (sel_plane != plane_t'(0)) && (sel_plane <= fetch_cnt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_req_o   <= 1'b0;
         fetch_plane_o <= '0;
         disp_planes_o <= '0;
         group_load_o  <= 1'b0;
      end else begin
         fetch_req_o   <= req_c;
         fetch_plane_o <= req_c ? sel_plane : plane_t'(0);
         disp_planes_o <= disp_cnt;
         group_load_o  <= req_c && (sel_plane == plane_t'(1));
      end
   end

   // output checks, next to the registers they guard
   assert_idle_plane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req_o |-> fetch_plane_o == 3'd0);

   assert_plane_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o |-> (fetch_plane_o != 3'd0 && fetch_plane_o <= 3'd6));

   assert_zero_planes_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(plane_req_i) == 3'd0) |-> (!fetch_req_o && disp_planes_o == 3'd0));

   assert_seven_plane_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(plane_req_i) == 3'd7) |->
         (disp_planes_o == 3'd6 && (!fetch_req_o || fetch_plane_o <= 3'd4)));

   assert_hires_low_planes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(hires_i) && fetch_req_o) |-> fetch_plane_o <= 3'd4);

   assert_start_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o |-> $past(slot_i) >= SLOT_W'(MIN_START));

   assert_load_with_plane1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      group_load_o |-> (fetch_req_o && fetch_plane_o == 3'd1));
endmodule

// File: tb/bpl_fetch_seq_tb_top.sv
module bpl_fetch_seq_tb_top;
   localparam int SLOT_W    = 9;
   localparam int MIN_START = 24;
   localparam int SWEEP     = 260;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              hires_i;
   logic [2:0]        plane_req_i;
   logic [SLOT_W-1:0] win_start_i;
   logic [SLOT_W-1:0] win_stop_i;
   logic [SLOT_W-1:0] slot_i;
   logic              fetch_req_o;
   logic [2:0]        fetch_plane_o;
   logic [2:0]        disp_planes_o;
   logic              group_load_o;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   always #4 clk = ~clk;   // 125 MHz

   bpl_fetch_seq #(.SLOT_W(SLOT_W), .MIN_START(MIN_START)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .hires_i       (hires_i),
      .plane_req_i   (plane_req_i),
      .win_start_i   (win_start_i),
      .win_stop_i    (win_stop_i),
      .slot_i        (slot_i),
      .fetch_req_o   (fetch_req_o),
      .fetch_plane_o (fetch_plane_o),
      .disp_planes_o (disp_planes_o),
      .group_load_o  (group_load_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int eff_start(input int st);
      return (st < MIN_START) ? MIN_START : st;
   endfunction

   function automatic int exp_plane(input bit hi, input int req, input int st,
                                    input int sp, input int s);
      int es, g, fc, pos, p;
      es = eff_start(st);
      g  = hi ? 4 : 8;
      fc = (req == 7) ? 4 : req;
      if (s < es || sp < es) return 0;
      if ((s - es) / g > (sp - es) / g) return 0;
      pos = (s - es) % g;
      if (hi) begin
         case (pos)
            0: p = 4;
            1: p = 2;
            2: p = 3;
            default: p = 1;
         endcase
      end else begin
         case (pos)
            1: p = 4;
            2: p = 6;
            3: p = 2;
            5: p = 3;
            6: p = 5;
            7: p = 1;
            default: p = 0;
         endcase
      end
      if (p == 0 || p > fc) return 0;
      return p;
   endfunction

   function automatic string tag_for(input bit hi, input int req, input int st,
                                     input int sp, input int s);
      int es;
      es = eff_start(st);
      if (req == 0) return "R4";
      if (req == 7) return "R5";
      if (s < es) return "R6";
      if (sp < es || s > sp) return "R7";
      if (req < 6 && !hi) return "R3";
      return hi ? "R2" : "R1";
   endfunction

   // sweep one line for a configuration, one slot per cycle
   task automatic run_cfg(input bit hi, input int req, input int st, input int sp);
      int p;
      hires_i     = hi;
      plane_req_i = 3'(req);
      win_start_i = SLOT_W'(st);
      win_stop_i  = SLOT_W'(sp);
      for (int s = 0; s < SWEEP; s++) begin
         slot_i = SLOT_W'(s);
         @(negedge clk);
         p = exp_plane(hi, req, st, sp, s);
         check(tag_for(hi, req, st, sp, s), "plane", int'(fetch_plane_o), p);
         check(tag_for(hi, req, st, sp, s), "request", int'(fetch_req_o), int'(p != 0));
         check("R8", "group load", int'(group_load_o), int'(p == 1));
         check("R5", "display count", int'(disp_planes_o), (req == 7) ? 6 : req);
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 200000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin : main
      int seed;
      seed        = $urandom(32'd4117);
      rst_n       = 1'b0;
      hires_i     = 1'b1;
      plane_req_i = 3'd6;
      win_start_i = SLOT_W'(30);
      win_stop_i  = SLOT_W'(200);
      slot_i      = SLOT_W'(40);
      repeat (3) @(negedge clk);
      // R9: reset clears every output
      check("R9", "reset request", int'(fetch_req_o), 0);
      check("R9", "reset plane", int'(fetch_plane_o), 0);
      check("R9", "reset display", int'(disp_planes_o), 0);
      check("R9", "reset load", int'(group_load_o), 0);
      rst_n = 1'b1;

      // directed corners
      run_cfg(1'b0, 6, 32, 95);    // R1 full low-res set
      run_cfg(1'b1, 4, 40, 121);   // R2 high-res, stop inside group
      run_cfg(1'b0, 6, 4, 60);     // R6 start below floor
      run_cfg(1'b0, 0, 30, 200);   // R4 no planes
      run_cfg(1'b0, 7, 30, 100);   // R5 seven planes, low res
      run_cfg(1'b1, 7, 24, 47);    // R5 seven planes, high res
      run_cfg(1'b0, 3, 50, 49);    // R7 stop before start
      run_cfg(1'b0, 2, 24, 24);    // R7 single group from one-slot window
      run_cfg(1'b1, 1, 100, 103);  // R3 single plane

      // R9: registered latency, a single-slot pulse of plane 1
      hires_i = 1'b1; plane_req_i = 3'd4;
      win_start_i = SLOT_W'(24); win_stop_i = SLOT_W'(27);
      slot_i = SLOT_W'(27);
      @(posedge clk); #1;
      check("R9", "load after edge", int'(group_load_o), 1);
      slot_i = SLOT_W'(28);
      @(negedge clk);
      check("R9", "held until next edge", int'(group_load_o), 1);
      @(negedge clk);
      check("R9", "cleared after window", int'(fetch_req_o), 0);

      // constrained random configurations
      for (int n = 0; n < 30; n++) begin
         bit hi;
         int req, st, sp;
         hi  = 1'($urandom_range(1, 0));
         req = int'($urandom_range(7, 0));
         st  = int'($urandom_range(120, 0));
         sp  = int'($urandom_range(240, 10));
         run_cfg(hi, req, st, sp);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule